// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes an SDRAM device from an unknown power-on condition to a ready state. After reset is released, it drives the command pins through a fixed schedule. First comes a long idle wait. Then all banks are closed. Then a set of auto-refresh commands is issued. Last, the mode register is loaded. Every wait is counted in cycles for a 7 ns clock period. The same schedule therefore stays legal at every slower clock up to that period, including 100 and 125 MHz. The start-up time grows a little at the slower rates.

The sequencer owns the command bus until it raises `init_done`. From then on it keeps driving idle commands, and the normal controller takes over the bus. The mode word selects CAS latency 3, burst length 4, sequential burst order and writes in programmed bursts. It is built from parameters. The state machine moves through these states in order:

- `ST_PWRUP`: idle wait.
- `ST_PRE`: close all banks.
- `ST_PRE_GAP`: wait after the bank close.
- `ST_REF`: issue one auto-refresh.
- `ST_REF_GAP`: wait after the refresh. It returns to `ST_REF` until the last refresh, then moves on.
- `ST_MRS`: load the mode register.
- `ST_MRS_GAP`: wait after the mode load.
- `ST_READY`: final state, held until the next reset.

Each timed state leaves when its down-counter reaches zero. `ST_PRE`, `ST_REF` and `ST_MRS` last exactly one cycle each.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While reset is low, and in the first cycle after it, the pins show an idle command: {cs_n,ras_n,cas_n,we_n}=0111 with address and bank zero. `init_done` is 0.
- R2: After reset is released, the pins carry an idle command (0111) for the first 28600 cycles. Cycle k means the cycle after the k-th rising edge with reset high. Cycle 28601 carries the first non-idle command.
- R3: Cycle 28601 carries precharge-all: code 0010, address bit 10 high, all other address bits 0, bank 0. Exactly two idle cycles follow it.
- R4: Exactly eight auto-refresh commands (code 0001) are issued, starting at cycle 28604. Each is followed by exactly nine idle cycles, so the refreshes lie 10 cycles apart.
- R5: Cycle 28684 carries a mode-register load: code 0000, bank 0, address 0x032. In that address, bits 2:0=010 select burst length 4, bit 3=0 selects sequential order, bits 6:4=011 select CAS latency 3, bit 9=0 selects programmed-burst writes, and all other bits are 0. Two idle cycles follow it.
- R6: `init_done` stays 0 until both idle cycles after the mode load are done. It rises in cycle 28687 and stays 1 while reset is high. The pins show idle commands from then on.
- R7: In every cycle, `sd_cke` is 1, every `sd_dqm` bit is 1 and `sd_dq_oe` is 0.
- R8: A reset applied at any point forces the R1 state at once. It clears `init_done`, and the whole schedule restarts from R2 when reset is released.
- R9: No command other than idle, precharge, refresh or mode load ever appears on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, period 7 ns or longer |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_cke | output | 1 | Clock enable to the device, held high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ROW_W | Address bus, which carries the mode word and the precharge-all bit |
| sd_dqm | output | DQM_W | Byte masks, held high |
| sd_dq_oe | output | 1 | Data bus output enable, held low (bus released) |
| init_done | output | 1 | Sequence finished; the command bus may be handed over |

## Verification
All pins come from registers that update at the same edge as the state register. The command for state S therefore appears in the cycle right after the edge that enters S. The bench counts cycles from the first rising edge after reset is released. It expects the precharge in cycle 28601, refresh n in cycle 28604+10n, the mode load in cycle 28684 and `init_done` from cycle 28687. It samples every pin at the falling edge in the middle of each cycle and compares it with the value computed for that cycle index. After each reset, the bench resets its cycle index to zero, including resets that abort a sequence part-way through.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

    // Command codes are {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sdcmd_e;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_PRE,
        ST_PRE_GAP,
        ST_REF,
        ST_REF_GAP,
        ST_MRS,
        ST_MRS_GAP,
        ST_READY
    } seq_state_e;

    function automatic logic [2:0] burst_code(input int unsigned blen);
        case (blen)
            1:       return 3'b000;
            2:       return 3'b001;
            4:       return 3'b010;
            8:       return 3'b011;
            default: return 3'b111;
        endcase
    endfunction

    // Mode word: burst length code, sequential order, CAS latency,
    // programmed-burst writes, reserved bits zero.
    function automatic logic [31:0] mode_word(input int unsigned cas_lat,
                                              input int unsigned blen);
        logic [31:0] w;
        w        = '0;
        w[2:0]   = burst_code(blen);
        w[3]     = 1'b0;
        w[6:4]   = cas_lat[2:0];
        w[9]     = 1'b0;
        return w;
    endfunction

endpackage

// File: rtl/sdinit_countdown.sv
module sdinit_countdown #(
    parameter int unsigned CNT_W   = 15,
    parameter int unsigned RST_VAL = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= CNT_W'(RST_VAL);
        end else if (load) begin
            count_q <= load_val;
        end else if (count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign zero = (count_q == '0);

endmodule

// File: rtl/sdinit_pin_drive.sv
module sdinit_pin_drive
    import sdinit_pkg::*;
#(
    parameter int unsigned ROW_W     = 13,
    parameter int unsigned BANK_W    = 2,
    parameter int unsigned DQM_W     = 2,
    parameter int unsigned PALL_BIT  = 10,
    parameter logic [31:0] MODE_BITS = 32'h32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sdcmd_e            cmd_d,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ROW_W-1:0]  sd_addr,
    output logic [DQM_W-1:0]  sd_dqm,
    output logic              sd_dq_oe
);

    logic [ROW_W-1:0] addr_d;

    // Each address bit carries either a mode-word bit or the all-banks flag
    for (genvar b = 0; b < ROW_W; b++) begin : g_addr
        if (b == PALL_BIT) begin : g_pall
            assign addr_d[b] = (cmd_d == CMD_PRE) ||
                               ((cmd_d == CMD_MRS) && MODE_BITS[b]);
        end else begin : g_plain
            assign addr_d[b] = (cmd_d == CMD_MRS) && MODE_BITS[b];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= CMD_NOP;
            sd_addr  <= '0;
            sd_ba    <= '0;
            sd_dqm   <= '1;
            sd_cke   <= 1'b1;
            sd_dq_oe <= 1'b0;
        end else begin
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= cmd_d;
            sd_addr  <= addr_d;
            sd_ba    <= '0;
            sd_dqm   <= '1;
            sd_cke   <= 1'b1;
            sd_dq_oe <= 1'b0;
        end
    end

endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq
    import sdinit_pkg::*;
#(
    parameter int unsigned PWRUP_CYCLES = 28600,
    parameter int unsigned PRE_GAP      = 2,
    parameter int unsigned REF_COUNT    = 8,
    parameter int unsigned REF_GAP      = 9,
    parameter int unsigned MRS_GAP      = 2,
    parameter int unsigned CAS_LAT      = 3,
    parameter int unsigned BURST_LEN    = 4,
    parameter int unsigned ROW_W        = 13,
    parameter int unsigned BANK_W       = 2,
    parameter int unsigned DQM_W        = 2,
    parameter int unsigned PALL_BIT     = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ROW_W-1:0]  sd_addr,
    output logic [DQM_W-1:0]  sd_dqm,
    output logic              sd_dq_oe,
    output logic              init_done
);

    localparam int unsigned TMR_W     = $clog2(PWRUP_CYCLES + 1);
    localparam int unsigned REFC_W    = $clog2(REF_COUNT + 1);
    localparam logic [31:0] MODE_BITS = mode_word(CAS_LAT, BURST_LEN);

    seq_state_e        state_q, state_d;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_zero;
    logic [REFC_W-1:0] ref_cnt_q;
    logic              ref_inc;
    logic              last_ref;
    sdcmd_e            cmd_d;
    logic              done_q;

    sdinit_countdown #(
        .CNT_W   (TMR_W),
        .RST_VAL (PWRUP_CYCLES)
    ) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    assign last_ref = (ref_cnt_q == REFC_W'(REF_COUNT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_cnt_q <= '0;
        end else if (ref_inc) begin
            ref_cnt_q <= ref_cnt_q + 1'b1;
        end
    end

    // Transition logic
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        ref_inc  = 1'b0;
        unique case (state_q)
            ST_PWRUP: begin
                if (tmr_zero) state_d = ST_PRE;
            end
            ST_PRE: begin
                state_d  = ST_PRE_GAP;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(PRE_GAP - 1);
            end
            ST_PRE_GAP: begin
                if (tmr_zero) state_d = ST_REF;
            end
            ST_REF: begin
                state_d  = ST_REF_GAP;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(REF_GAP - 1);
            end
            ST_REF_GAP: begin
                if (tmr_zero) begin
                    if (last_ref) begin
                        state_d = ST_MRS;
                    end else begin
                        state_d = ST_REF;
                        ref_inc = 1'b1;
                    end
                end
            end
            ST_MRS: begin
                state_d  = ST_MRS_GAP;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(MRS_GAP - 1);
            end
            ST_MRS_GAP: begin
                if (tmr_zero) state_d = ST_READY;
            end
            ST_READY: begin
                state_d = ST_READY;
            end
            default: begin
                state_d = ST_PWRUP;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PWRUP;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode, registered together with the state
    always_comb begin
        unique case (state_d)
            ST_PRE:  cmd_d = CMD_PRE;
            ST_REF:  cmd_d = CMD_REF;
            ST_MRS:  cmd_d = CMD_MRS;
            default: cmd_d = CMD_NOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= (state_d == ST_READY);
        end
    end

    assign init_done = done_q;

    sdinit_pin_drive #(
        .ROW_W     (ROW_W),
        .BANK_W    (BANK_W),
        .DQM_W     (DQM_W),
        .PALL_BIT  (PALL_BIT),
        .MODE_BITS (MODE_BITS)
    ) u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_d    (cmd_d),
        .sd_cke   (sd_cke),
        .sd_cs_n  (sd_cs_n),
        .sd_ras_n (sd_ras_n),
        .sd_cas_n (sd_cas_n),
        .sd_we_n  (sd_we_n),
        .sd_ba    (sd_ba),
        .sd_addr  (sd_addr),
        .sd_dqm   (sd_dqm),
        .sd_dq_oe (sd_dq_oe)
    );

endmodule

// File: rtl/sdram_powerup_seq_chk.sv
module sdram_powerup_seq_chk
    import sdinit_pkg::*;
#(
    parameter int unsigned PWRUP_CYCLES = 28600,
    parameter int unsigned CAS_LAT      = 3,
    parameter int unsigned BURST_LEN    = 4,
    parameter int unsigned ROW_W        = 13,
    parameter int unsigned BANK_W       = 2,
    parameter int unsigned DQM_W        = 2,
    parameter int unsigned PALL_BIT     = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sd_cke,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [BANK_W-1:0] sd_ba,
    input logic [ROW_W-1:0]  sd_addr,
    input logic [DQM_W-1:0]  sd_dqm,
    input logic              sd_dq_oe,
    input logic              init_done
);

    localparam logic [31:0] MODE_BITS = mode_word(CAS_LAT, BURST_LEN);

    logic [3:0]  cmd;
    logic [31:0] since_rst_q;

    assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst_q <= '0;
        end else if (since_rst_q != '1) begin
            since_rst_q <= since_rst_q + 1'b1;
        end
    end

    // R2
    pwrup_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NOP) |-> (since_rst_q >= PWRUP_CYCLES));

    // R3
    pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE) |-> (sd_addr[PALL_BIT] && (sd_ba == '0)));

    // R3
    pre_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE) |=> (cmd == CMD_NOP));

    // R4
    ref_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REF) |=> (cmd == CMD_NOP));

    // R5
    mrs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_MRS) |-> ((sd_addr == MODE_BITS[ROW_W-1:0]) && (sd_ba == '0)));

    // R6
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (cmd == CMD_NOP));

    // R6
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> ($past(cmd) == CMD_NOP));

    // R7
    pins_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cke && (&sd_dqm) && !sd_dq_oe));

    // R9
    legal_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == CMD_NOP) || (cmd == CMD_PRE) || (cmd == CMD_REF) || (cmd == CMD_MRS)));

endmodule

bind sdram_powerup_seq sdram_powerup_seq_chk #(
    .PWRUP_CYCLES (PWRUP_CYCLES),
    .CAS_LAT      (CAS_LAT),
    .BURST_LEN    (BURST_LEN),
    .ROW_W        (ROW_W),
    .BANK_W       (BANK_W),
    .DQM_W        (DQM_W),
    .PALL_BIT     (PALL_BIT)
) u_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sd_cke    (sd_cke),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_ba     (sd_ba),
    .sd_addr   (sd_addr),
    .sd_dqm    (sd_dqm),
    .sd_dq_oe  (sd_dq_oe),
    .init_done (init_done)
);

// File: tb/test_sdram_powerup_seq.sv
module test_sdram_powerup_seq;

    localparam int P_WAIT  = 28600;
    localparam int G_PRE   = 2;
    localparam int N_REF   = 8;
    localparam int G_REF   = 9;
    localparam int G_MRS   = 2;
    localparam int T_PRE   = P_WAIT + 1;
    localparam int T_REF0  = T_PRE + 1 + G_PRE;
    localparam int T_MRS   = T_REF0 + N_REF * (1 + G_REF);
    localparam int T_DONE  = T_MRS + 1 + G_MRS;

    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_MRS = 4'b0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe, init_done;
    logic [1:0]  sd_ba;
    logic [12:0] sd_addr;
    logic [1:0]  sd_dqm;
    int          n_cmp = 0;
    int          n_bad = 0;

    always #5 clk = ~clk;

    sdram_powerup_seq i_sdram_powerup_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sd_cke    (sd_cke),
        .sd_cs_n   (sd_cs_n),
        .sd_ras_n  (sd_ras_n),
        .sd_cas_n  (sd_cas_n),
        .sd_we_n   (sd_we_n),
        .sd_ba     (sd_ba),
        .sd_addr   (sd_addr),
        .sd_dqm    (sd_dqm),
        .sd_dq_oe  (sd_dq_oe),
        .init_done (init_done)
    );

    // Mode word from R5: BL4 code 010, sequential, CL3 in bits 6:4
    function automatic logic [12:0] mode_val();
        return (13'd3 << 4) | 13'd2;
    endfunction

    function automatic logic [3:0] exp_cmd(input int i);
        if (i == T_PRE) return C_PRE;
        if (i >= T_REF0 && i < T_MRS && ((i - T_REF0) % (1 + G_REF)) == 0) return C_REF;
        if (i == T_MRS) return C_MRS;
        return C_NOP;
    endfunction

    function automatic logic [12:0] exp_addr(input int i);
        if (i == T_PRE) return 13'h0400;
        if (i == T_MRS) return mode_val();
        return 13'h0000;
    endfunction

    function automatic string req_of(input int i);
        if (i < T_PRE)  return "R2";
        if (i < T_REF0) return "R3";
        if (i < T_MRS)  return "R4";
        if (i < T_DONE) return "R5";
        return "R6";
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int i, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s cycle %0d: actual %0h expected %0h", req, what, i, act, exp);
        end
    endtask

    task automatic check_pins_quiet(input int i);
        // R7
        chk(sd_cke == 1'b1 && sd_dqm == 2'b11 && sd_dq_oe == 1'b0, "R7",
            "cke/dqm/oe", i, {29'd0, sd_cke, &sd_dqm, sd_dq_oe}, 32'h6);
    endtask

    task automatic check_cycle(input int i);
        logic [3:0] c;
        c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        chk(c == exp_cmd(i), req_of(i), "cmd", i, {28'd0, c}, {28'd0, exp_cmd(i)});
        chk(sd_addr == exp_addr(i) && sd_ba == 2'b00, req_of(i), "addr/ba", i,
            {17'd0, sd_ba, sd_addr}, {19'd0, exp_addr(i)});
        chk(init_done == (i >= T_DONE), "R6", "init_done", i,
            {31'd0, init_done}, {31'd0, (i >= T_DONE)});
        // R9
        chk(c == C_NOP || c == C_PRE || c == C_REF || c == C_MRS, "R9", "legal cmd",
            i, {28'd0, c}, {28'd0, C_NOP});
        check_pins_quiet(i);
    endtask

    // Hold reset for len cycles, checking the idle state, then release
    task automatic apply_reset(input int len, input string req);
        @(negedge clk);
        rst_n = 1'b0;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP && sd_addr == '0 &&
                init_done == 1'b0, req, "reset state", k,
                {15'd0, init_done, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_addr},
                {15'd0, 1'b0, C_NOP, 13'd0});
            check_pins_quiet(k);
        end
        rst_n = 1'b1;
    endtask

    task automatic run_cycles(input int n);
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            check_cycle(i);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL R6 watchdog: actual run unfinished, expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        // R1, R2..R6: directed full sequence
        apply_reset(3, "R1");
        run_cycles(T_DONE + 20);
        // R8: abort inside the refresh train, then a full restart
        apply_reset(2, "R8");
        run_cycles(T_REF0 + 37);
        apply_reset($urandom_range(1, 6), "R8");
        run_cycles(T_DONE + 20);
        // R8: random abort near the end of the sequence
        apply_reset($urandom_range(1, 6), "R8");
        run_cycles($urandom_range(P_WAIT - 3, T_DONE + 5));
        // R8: random early abort
        apply_reset($urandom_range(1, 6), "R8");
        run_cycles($urandom_range(1, 300));
        // R8: final full run after the aborts
        apply_reset($urandom_range(1, 6), "R8");
        run_cycles(T_DONE + 20);
        summary();
        $finish;
    end

endmodule